// File: doc/BRIEF.md
# Destructive-Read Memory Cycle Controller

This block sequences accesses to a word-organised storage array that behaves like magnetic core. Sensing a cell returns its word and leaves the cell at zero. Driving a cell can only turn bits on, so a store ORs its data into whatever the cell already holds. A CPU-side port presents one request at a time with a valid/ready handshake. The controller turns each request into the matching series of array phases: a sense phase, then an optional drive phase. Each phase lasts a parameterised number of clock cycles.

Four request kinds are supported. A plain fetch senses the word and drives it back. A plain store senses the cell to clear it, then drives the new data. A fetch-and-clear senses the word and skips the drive, so it finishes earlier and leaves the cell at zero. An atomic byte claim senses the word, reports the top bit of the addressed byte, and in the same sequence drives that byte back as all ones. The other bytes of the word are restored unchanged. A behavioural model of the array is part of the block.

Top module: `drm_cycle_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every array word reads as zero.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the cycle after acceptance until the response cycle. Requests presented while busy have no effect. `req_op` encodes 00 fetch, 01 store, 10 fetch-and-clear, 11 byte claim.
- R3: A fetch (00) returns the stored word in `rsp_rdata` and leaves the cell unchanged. `rsp_valid` rises RD_CYC+WR_CYC+1 cycles after the accepting edge's cycle.
- R4: A store (01) leaves the cell holding exactly `req_wdata`, with no bits kept from the old contents. `rsp_rdata` returns the old contents. The latency is the same as a fetch.
- R5: A fetch-and-clear (10) returns the stored word and leaves the cell at zero. `rsp_valid` rises RD_CYC+1 cycles after the accepting cycle.
- R6: A byte claim (11) returns the whole old word. `rsp_flag` is bit 7 of byte lane k, where k = `req_addr[1:0]` and lane k is bits 8k+7..8k. Lane k becomes 8'hFF and the other lanes keep their old values. The latency is the same as a fetch.
- R7: `rsp_flag` is 0 in responses to request kinds 00, 01 and 10.
- R8: `rsp_valid` is a one-cycle pulse, and `req_ready` is high in that cycle.
- R9: Every drive phase targets a cell that the sense phase of the same sequence has already cleared. A drive phase never clears a bit.
- R10: Request kinds 00, 01 and 10 address the word `req_addr[ADDR_W+1:2]`. For these kinds the two low address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | Request kind |
| req_addr | input | ADDR_W+2 | Byte address; the upper bits select the word |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word sensed by the request |
| rsp_flag | output | 1 | Byte-claim condition bit |

## Verification
The hardest case to reach from the ports is a request that arrives while the controller is busy. It must not disturb the cell, and it is only visible as a cell that later reads back unchanged. The stimulus holds `req_valid` high with a fetch-and-clear aimed at a second, loaded word for the whole busy window. It drops `req_valid` just before the response edge, then fetches that word and expects its old value. Repeated byte claims on one word walk the flag from 1 to 0 to 1 as lanes fill with ones. A seeded random mix of all four kinds is compared against a behavioural model on every cycle.

// File: rtl/drm_pkg.sv
package drm_pkg;
    typedef enum logic [1:0] {
        OP_FETCH = 2'b00,
        OP_STORE = 2'b01,
        OP_CLEAR = 2'b10,
        OP_CLAIM = 2'b11
    } drm_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_SENSE = 2'b01,
        PH_DRIVE = 2'b10
    } drm_phase_e;
endpackage

// File: rtl/drm_core_array.sv
// Behavioural storage: sensing zeroes the cell, driving can only set bits.
module drm_core_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic              sense_stb,
    input  logic              drive_stb,
    input  logic [DATA_W-1:0] drive_data,
    output logic [DATA_W-1:0] cell_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    assign cell_word = cells_q[cell_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (sense_stb) begin
            cells_q[cell_addr] <= '0;
        end else if (drive_stb) begin
            cells_q[cell_addr] <= cells_q[cell_addr] | drive_data;
        end
    end
endmodule

// File: rtl/drm_restore_mux.sv
// Chooses the word driven back in the drive phase and derives the claim flag.
module drm_restore_mux
    import drm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  drm_op_e           op,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] sensed,
    input  logic [DATA_W-1:0] new_data,
    output logic [DATA_W-1:0] restore,
    output logic              claim_flag
);
    logic [DATA_W-1:0] claimed;
    logic [LANES-1:0]  lane_top;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign claimed[g*8 +: 8] = (lane == LANE_W'(g)) ? 8'hFF : sensed[g*8 +: 8];
        assign lane_top[g]       = sensed[g*8 + 7];
    end

    assign claim_flag = lane_top[lane];

    always_comb begin
        case (op)
            OP_STORE: restore = new_data;
            OP_CLAIM: restore = claimed;
            default:  restore = sensed;
        endcase
    end
endmodule

// File: rtl/drm_phase_seq.sv
// Phase sequencer: sense phase, then an optional drive phase, per request kind.
module drm_phase_seq
    import drm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 2,
    parameter int DATA_W = 32,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [ADDR_W+LANE_W-1:0] req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [ADDR_W-1:0]        cell_addr,
    output logic                     sense_stb,
    output logic                     drive_stb,
    input  logic [DATA_W-1:0]        cell_word,
    input  logic                     claim_flag,
    output drm_op_e                  cur_op,
    output logic [LANE_W-1:0]        cur_lane,
    output logic [DATA_W-1:0]        cur_wdata,
    output logic [DATA_W-1:0]        sensed_word,
    output logic                     rsp_valid,
    output logic                     rsp_flag
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        drm_phase_e         phase;
        logic [CNT_W-1:0]   cnt;
        drm_op_e            op;
        logic [ADDR_W-1:0]  waddr;
        logic [LANE_W-1:0]  lane;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  word;
        logic               rsp;
        logic               flag;
    } seq_t;

    seq_t s_d, s_q;
    logic sense_end, drive_end;

    assign sense_end = (s_q.phase == PH_SENSE) && (s_q.cnt == CNT_W'(RD_CYC - 1));
    assign drive_end = (s_q.phase == PH_DRIVE) && (s_q.cnt == CNT_W'(WR_CYC - 1));

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_SENSE;
                    s_d.cnt   = '0;
                    s_d.op    = drm_op_e'(req_op);
                    s_d.waddr = req_addr[ADDR_W+LANE_W-1:LANE_W];
                    s_d.lane  = req_addr[LANE_W-1:0];
                    s_d.wdata = req_wdata;
                end
            end
            PH_SENSE: begin
                if (sense_end) begin
                    s_d.word = cell_word;
                    s_d.cnt  = '0;
                    if (s_q.op == OP_CLEAR) begin
                        s_d.phase = PH_IDLE;
                        s_d.rsp   = 1'b1;
                        s_d.flag  = 1'b0;
                    end else begin
                        s_d.phase = PH_DRIVE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DRIVE: begin
                if (drive_end) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.rsp   = 1'b1;
                    s_d.flag  = (s_q.op == OP_CLAIM) ? claim_flag : 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, op: OP_FETCH, waddr: '0, lane: '0,
                     wdata: '0, word: '0, rsp: 1'b0, flag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.phase == PH_IDLE);
    assign cell_addr   = s_q.waddr;
    assign sense_stb   = sense_end;
    assign drive_stb   = drive_end;
    assign cur_op      = s_q.op;
    assign cur_lane    = s_q.lane;
    assign cur_wdata   = s_q.wdata;
    assign sensed_word = s_q.word;
    assign rsp_valid   = s_q.rsp;
    assign rsp_flag    = s_q.flag;
endmodule

// File: rtl/drm_cycle_ctrl.sv
module drm_cycle_ctrl
    import drm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W+1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_flag
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [ADDR_W-1:0] arr_addr;
    logic              arr_sense;
    logic              arr_drive;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] arr_restore;
    logic              claim_flag;
    drm_op_e           cur_op;
    logic [LANE_W-1:0] cur_lane;
    logic [DATA_W-1:0] cur_wdata;
    logic [DATA_W-1:0] sensed_word;

    drm_phase_seq #(
        .ADDR_W(ADDR_W), .LANE_W(LANE_W), .DATA_W(DATA_W),
        .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cell_addr  (arr_addr),
        .sense_stb  (arr_sense),
        .drive_stb  (arr_drive),
        .cell_word  (arr_word),
        .claim_flag (claim_flag),
        .cur_op     (cur_op),
        .cur_lane   (cur_lane),
        .cur_wdata  (cur_wdata),
        .sensed_word(sensed_word),
        .rsp_valid  (rsp_valid),
        .rsp_flag   (rsp_flag)
    );

    drm_restore_mux #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_mux (
        .op        (cur_op),
        .lane      (cur_lane),
        .sensed    (sensed_word),
        .new_data  (cur_wdata),
        .restore   (arr_restore),
        .claim_flag(claim_flag)
    );

    drm_core_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_addr (arr_addr),
        .sense_stb (arr_sense),
        .drive_stb (arr_drive),
        .drive_data(arr_restore),
        .cell_word (arr_word)
    );

    assign rsp_rdata = sensed_word;
endmodule

// File: rtl/drm_cycle_chk.sv
module drm_cycle_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sense_stb,
    input logic              drive_stb,
    input logic [DATA_W-1:0] cell_word
);
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    rsp_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R8
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    drive_into_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> (cell_word == '0));

    // R2
    one_phase_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sense_stb && drive_stb));

    // R2
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(sense_stb || drive_stb));
endmodule

bind drm_cycle_ctrl drm_cycle_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .sense_stb(arr_sense),
    .drive_stb(arr_drive),
    .cell_word(arr_word)
);

// File: tb/sim_drm_cycle_ctrl.sv
module sim_drm_cycle_ctrl;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int RD_CYC = 2;
    localparam int WR_CYC = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'b00;
    logic [ADDR_W+1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_flag;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] model_mem [64];

    always #4 clk = ~clk;

    drm_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_flag(rsp_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request, compared with the model on every cycle until the response.
    task automatic do_req(input logic [1:0] op, input logic [7:0] baddr, input logic [31:0] wd,
                          input string req, input bit poke = 1'b0, input logic [7:0] poke_addr = '0);
        int w  = int'(baddr[7:2]);
        int ln = int'(baddr[1:0]);
        logic [31:0] old = model_mem[w];
        logic [31:0] nxt;
        logic        eflag;
        int lat;
        lat   = (op == 2'b10) ? RD_CYC + 1 : RD_CYC + WR_CYC + 1;
        eflag = (op == 2'b11) ? old[ln*8 + 7] : 1'b0;
        case (op)
            2'b00: nxt = old;
            2'b01: nxt = wd;
            2'b10: nxt = '0;
            default: begin nxt = old; nxt[ln*8 +: 8] = 8'hFF; end
        endcase
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_op = op; req_addr = baddr; req_wdata = wd;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (poke) begin
                    req_op = 2'b10; req_addr = poke_addr; req_wdata = 32'hFFFF_FFFF;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (k == lat) req_valid = 1'b0;
            if (k < lat) begin
                chk(!req_ready && !rsp_valid, {"R2 busy ", req}, {30'd0, req_ready, rsp_valid}, 32'd0);
            end else begin
                chk(rsp_valid && req_ready, {"R8 response ", req}, {30'd0, req_ready, rsp_valid}, 32'd3);
                chk(rsp_rdata == old, {req, " data"}, rsp_rdata, old);
                chk(rsp_flag == eflag, {req, " flag"}, 32'(rsp_flag), 32'(eflag));
            end
        end
        model_mem[w] = nxt;
        @(negedge clk);
        chk(!rsp_valid, "R8 pulse ends", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        do_req(2'b00, 8'd40, '0, "R1 fresh word zero");

        do_req(2'b01, 8'd20, 32'h1234_5678, "R4 store into empty");
        do_req(2'b00, 8'd20, '0, "R3 fetch");
        do_req(2'b00, 8'd20, '0, "R3 fetch restored");
        do_req(2'b01, 8'd20, 32'h0F0F_0000, "R4 overwrite no OR residue");
        do_req(2'b00, 8'd20, '0, "R4 check overwrite");
        do_req(2'b10, 8'd20, '0, "R5 fetch-and-clear");
        do_req(2'b00, 8'd20, '0, "R5 cell left zero");

        do_req(2'b01, 8'd28, 32'h8000_1122, "R6 load word");
        do_req(2'b11, 8'd31, '0, "R6 claim lane 3 set");
        do_req(2'b11, 8'd28, '0, "R6 claim lane 0 clear");
        do_req(2'b11, 8'd28, '0, "R6 claim lane 0 again");
        do_req(2'b11, 8'd29, '0, "R6 claim lane 1 clear");
        do_req(2'b00, 8'd28, '0, "R6 other lanes kept");
        do_req(2'b00, 8'd28, '0, "R7 fetch flag zero");

        do_req(2'b01, 8'd51, 32'hCAFE_F00D, "R10 store low bits set");
        do_req(2'b00, 8'd50, '0, "R10 fetch other low bits");
        do_req(2'b10, 8'd49, '0, "R10 clear via other low bits");
        do_req(2'b00, 8'd48, '0, "R10 word cleared");

        do_req(2'b01, 8'd60, 32'hA5A5_5A5A, "R2 load victim");
        do_req(2'b00, 8'd8, '0, "R2 busy request ignored", 1'b1, 8'd60);
        do_req(2'b00, 8'd60, '0, "R2 victim intact");

        void'($urandom(7));
        for (int n = 0; n < 120; n++) begin
            logic [1:0]  rop = 2'($urandom_range(0, 3));
            logic [7:0]  rad = {2'b00, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
            logic [31:0] rwd = $urandom;
            do_req(rop, rad, rwd, "R3 R4 R5 R6 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule